// File: doc/BRIEF.md
# Write Strobe Centering Tap Sequencer

This block places the write strobe in the middle of the write data eye once an edge scan has run. It drives two cascaded delay taps. The fine tap sets the phase between strobe and data. The compensating tap keeps the strobe-to-clock alignment that write leveling established. Every fine step is paired with a two-tap step of the compensating tap in the opposite direction.

A calibration controller supplies the scan results and pulses `start`. The scan results are four edge-found flags with a tap position for each edge, plus the fine-tap search limits and the starting values of both taps. The block picks a target from the set of edges that were found and clamps it into the search window. It then walks the fine tap toward the target one step at a time, waiting a settle interval after each step. When the fine tap reaches the target it pulses `done` and raises `relevel_req`, so the controller knows write leveling must be repeated using only the compensating tap. If the flag combination matches no case, it pulses `err` and leaves both taps at their loaded values.

Top module: `wsc_center_seq`

## Requirements
- R1: Each fine-tap decrement of one raises the compensating tap by two in the same cycle. If that would pass the top code (2^S2_W-1), the compensating tap stops at the top code instead.
- R2: Each fine-tap increment of one lowers the compensating tap by two in the same cycle. If that would go below zero, the compensating tap stops at zero instead.
- R3: Once the compensating tap sits at a bound, the fine tap keeps stepping toward its target and the compensating tap stays at that bound.
- R4: The target is the sum of two edge positions shifted right by one. `edge_found` bit 0 marks the falling-to-zero edge, bit 1 the zero-to-rising edge, bit 2 the rising-to-one edge and bit 3 the one-to-falling edge. The pair is chosen by the first rule in this list that matches: {bit0,bit1}, {bit1,bit2}, {bit2,bit3}, bit1 alone, bit0 alone, bit2 alone.
- R5: The {bit1,bit2} pair has QTR taps (90 degrees) subtracted from its midpoint. The {bit2,bit3} pair and the bit2-alone case have 2*QTR taps (180 degrees) subtracted. All other cases have no offset.
- R6: When a single edge was found, the missing partner position is replaced by a search limit. The bit1-alone case uses `lim_lo`. The bit0-alone and bit2-alone cases use `lim_hi`.
- R7: The target is clamped into the range [`lim_lo`, `lim_hi`], and an offset that would take it below zero gives `lim_lo`.
- R8: `done` is high for exactly one cycle, in the cycle the fine tap is first seen equal to the target. `relevel_req` rises in that same cycle and stays high until the next accepted `start`.
- R9: If the flags match no rule, `err` pulses for one cycle, both taps keep the values loaded at `start`, and `relevel_req` stays low.
- R10: A `start` that arrives while `busy` is high is ignored: the run in progress ends at the result of its own inputs.
- R11: After reset both taps are zero, and `busy`, `done`, `err` and `relevel_req` are low.
- R12: Consecutive fine-tap steps within one run are at least SETTLE+1 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a centering run; inputs are sampled on this cycle |
| edge_found | input | 4 | Edge-found flags, bit order as in R4 |
| pos_f2z | input | S3_W | Fine-tap position of the falling-to-zero edge |
| pos_z2f | input | S3_W | Fine-tap position of the zero-to-rising edge |
| pos_f2o | input | S3_W | Fine-tap position of the rising-to-one edge |
| pos_o2f | input | S3_W | Fine-tap position of the one-to-falling edge |
| lim_lo | input | S3_W | Left fine-tap search limit |
| lim_hi | input | S3_W | Right fine-tap search limit |
| init_s3 | input | S3_W | Fine-tap value at start |
| init_s2 | input | S2_W | Compensating-tap value at start |
| s3_tap | output | S3_W | Fine (strobe-to-data) tap |
| s2_tap | output | S2_W | Compensating (strobe-to-clock) tap |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse when the target is reached |
| err | output | 1 | One-cycle pulse when no rule matches |
| relevel_req | output | 1 | Request to repeat write leveling |

## Verification
The assertions check these properties on every cycle:
- the pairing of each fine step with its two-tap counter-step, and saturation at both bounds;
- the settle spacing between steps;
- the exclusivity of `done` and `err`, and the state of `relevel_req` when each of them pulses;
- that both taps hold still on an error;
- that the result lies inside the search window.

Whether the correct target was chosen can only be shown by the bench scenarios. Those scenarios cover each rule of the case table, both offsets, limit substitution, clamping, a run that starts already on target, an unmatched flag set, and an ignored second `start`.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CALC,
    ST_MOVE,
    ST_WAIT
  } wsc_state_t;
endpackage

// File: rtl/wsc_target.sv
// Chooses the centering target from the edge-found flags and clamps it.
module wsc_target #(
  parameter int S3_W = 6,
  parameter int QTR  = 8
) (
  input  logic [3:0]      found,
  input  logic [S3_W-1:0] p_f2z,
  input  logic [S3_W-1:0] p_z2f,
  input  logic [S3_W-1:0] p_f2o,
  input  logic [S3_W-1:0] p_o2f,
  input  logic [S3_W-1:0] lo,
  input  logic [S3_W-1:0] hi,
  output logic [S3_W-1:0] tgt,
  output logic            valid
);
  localparam int W = S3_W + 2;
  localparam logic [W-1:0] OFF90  = W'(QTR);
  localparam logic [W-1:0] OFF180 = W'(2 * QTR);

  logic [S3_W-1:0] ea, eb;
  logic [W-1:0]    off, mid, raw;

  always_comb begin
    valid = 1'b1;
    ea    = lo;
    eb    = hi;
    off   = '0;
    if (found[0] && found[1]) begin
      ea = p_f2z; eb = p_z2f;
    end else if (found[1] && found[2]) begin
      ea = p_z2f; eb = p_f2o; off = OFF90;
    end else if (found[2] && found[3]) begin
      ea = p_f2o; eb = p_o2f; off = OFF180;
    end else if (found[1]) begin
      ea = lo; eb = p_z2f;
    end else if (found[0]) begin
      ea = p_f2z; eb = hi;
    end else if (found[2]) begin
      ea = p_f2o; eb = hi; off = OFF180;
    end else begin
      valid = 1'b0;
    end
    mid = ({2'b00, ea} + {2'b00, eb}) >> 1;
    raw = mid - off;
    if (mid < off + {2'b00, lo})   tgt = lo;
    else if (raw > {2'b00, hi})    tgt = hi;
    else                           tgt = raw[S3_W-1:0];
  end
endmodule

// File: rtl/wsc_tap_step.sv
// Next values of the paired taps for one fine step.
module wsc_tap_step #(
  parameter int S3_W = 6,
  parameter int S2_W = 6
) (
  input  logic [S3_W-1:0] s3,
  input  logic [S2_W-1:0] s2,
  input  logic            up,
  output logic [S3_W-1:0] s3_n,
  output logic [S2_W-1:0] s2_n
);
  localparam logic [S2_W-1:0] S2_MAX  = {S2_W{1'b1}};
  localparam logic [S2_W-1:0] S2_HIGH = S2_MAX - S2_W'(2);
  localparam logic [S2_W-1:0] TWO     = S2_W'(2);

  always_comb begin
    if (up) begin
      s3_n = s3 + S3_W'(1);
      s2_n = (s2 < TWO) ? '0 : s2 - TWO;
    end else begin
      s3_n = s3 - S3_W'(1);
      s2_n = (s2 > S2_HIGH) ? S2_MAX : s2 + TWO;
    end
  end
endmodule

// File: rtl/wsc_center_seq.sv
// Top: latches scan results, computes target, steps taps with settle gaps.
module wsc_center_seq #(
  parameter int S3_W   = 6,
  parameter int S2_W   = 6,
  parameter int QTR    = 8,
  parameter int SETTLE = 16   // must be at least 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [3:0]      edge_found,
  input  logic [S3_W-1:0] pos_f2z,
  input  logic [S3_W-1:0] pos_z2f,
  input  logic [S3_W-1:0] pos_f2o,
  input  logic [S3_W-1:0] pos_o2f,
  input  logic [S3_W-1:0] lim_lo,
  input  logic [S3_W-1:0] lim_hi,
  input  logic [S3_W-1:0] init_s3,
  input  logic [S2_W-1:0] init_s2,
  output logic [S3_W-1:0] s3_tap,
  output logic [S2_W-1:0] s2_tap,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic            relevel_req
);
  import wsc_pkg::*;

  localparam int CNT_W = $clog2(SETTLE + 1);

  wsc_state_t      state;
  logic [3:0]      l_found;
  logic [S3_W-1:0] l_f2z, l_z2f, l_f2o, l_o2f, l_lo, l_hi;
  logic [S3_W-1:0] tgt_q, tgt_c, s3_n;
  logic [S2_W-1:0] s2_n;
  logic            tgt_ok;
  logic [CNT_W-1:0] cnt;

  wsc_target #(.S3_W(S3_W), .QTR(QTR)) u_target (
    .found(l_found), .p_f2z(l_f2z), .p_z2f(l_z2f), .p_f2o(l_f2o),
    .p_o2f(l_o2f), .lo(l_lo), .hi(l_hi), .tgt(tgt_c), .valid(tgt_ok)
  );

  wsc_tap_step #(.S3_W(S3_W), .S2_W(S2_W)) u_step (
    .s3(s3_tap), .s2(s2_tap), .up(s3_tap < tgt_q),
    .s3_n(s3_n), .s2_n(s2_n)
  );

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      s3_tap      <= '0;
      s2_tap      <= '0;
      done        <= 1'b0;
      err         <= 1'b0;
      relevel_req <= 1'b0;
      tgt_q       <= '0;
      cnt         <= '0;
      l_found     <= '0;
      l_f2z       <= '0;
      l_z2f       <= '0;
      l_f2o       <= '0;
      l_o2f       <= '0;
      l_lo        <= '0;
      l_hi        <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          l_found     <= edge_found;
          l_f2z       <= pos_f2z;
          l_z2f       <= pos_z2f;
          l_f2o       <= pos_f2o;
          l_o2f       <= pos_o2f;
          l_lo        <= lim_lo;
          l_hi        <= lim_hi;
          s3_tap      <= init_s3;
          s2_tap      <= init_s2;
          relevel_req <= 1'b0;
          state       <= ST_CALC;
        end
        ST_CALC: begin
          if (tgt_ok) begin
            tgt_q <= tgt_c;
            state <= ST_MOVE;
          end else begin
            err   <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_MOVE: begin
          if (s3_tap == tgt_q) begin
            done        <= 1'b1;
            relevel_req <= 1'b1;
            state       <= ST_IDLE;
          end else begin
            s3_tap <= s3_n;
            s2_tap <= s2_n;
            cnt    <= CNT_W'(SETTLE);
            state  <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          cnt <= cnt - CNT_W'(1);
          if (cnt <= CNT_W'(1)) state <= ST_MOVE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wsc_center_chk.sv
module wsc_center_chk #(
  parameter int S3_W   = 6,
  parameter int S2_W   = 6,
  parameter int SETTLE = 16
) (
  input logic            clk,
  input logic            rst,
  input logic [S3_W-1:0] s3_tap,
  input logic [S2_W-1:0] s2_tap,
  input logic [S3_W-1:0] lim_lo,
  input logic [S3_W-1:0] lim_hi,
  input logic            busy,
  input logic            done,
  input logic            err,
  input logic            relevel_req
);
  localparam int S2_MAX = (1 << S2_W) - 1;
  localparam int CNT_W  = $clog2(SETTLE + 1);

  logic [S3_W-1:0]  s3_d;
  logic             busy_d, armed, chg;
  logic [CNT_W-1:0] since;

  assign chg = (s3_tap != s3_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      s3_d   <= '0;
      busy_d <= 1'b0;
      armed  <= 1'b0;
      since  <= '0;
    end else begin
      s3_d   <= s3_tap;
      busy_d <= busy;
      if (chg) since <= '0;
      else if (int'(since) < SETTLE) since <= since + CNT_W'(1);
      if (!busy) armed <= 1'b0;
      else if (chg && busy_d) armed <= 1'b1;
    end
  end

  a_r1_dec_pairs_up: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && int'(s3_tap) + 1 == int'($past(s3_tap))) |->
      (int'(s2_tap) == int'($past(s2_tap)) + 2 ||
       (int'(s2_tap) == S2_MAX && int'($past(s2_tap)) > S2_MAX - 2)));

  a_r2_inc_pairs_down: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && int'(s3_tap) == int'($past(s3_tap)) + 1) |->
      (int'(s2_tap) + 2 == int'($past(s2_tap)) ||
       (s2_tap == '0 && int'($past(s2_tap)) < 2)));

  a_r3_hold_top: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && int'($past(s2_tap)) == S2_MAX &&
     int'(s3_tap) + 1 == int'($past(s3_tap))) |-> int'(s2_tap) == S2_MAX);

  a_r3_hold_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && $past(s2_tap) == '0 &&
     int'(s3_tap) == int'($past(s3_tap)) + 1) |-> s2_tap == '0);

  a_r7_in_window: assert property (@(posedge clk) disable iff (rst)
    done |-> (s3_tap >= lim_lo && s3_tap <= lim_hi));

  a_r8_done_flags: assert property (@(posedge clk) disable iff (rst)
    done |-> (relevel_req && !busy && !err));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_err_holds: assert property (@(posedge clk) disable iff (rst)
    err |-> (!relevel_req && !done && $stable(s3_tap) && $stable(s2_tap)));

  a_r12_settle_gap: assert property (@(posedge clk) disable iff (rst)
    (chg && busy_d && armed) |-> int'(since) >= SETTLE);
endmodule

bind wsc_center_seq wsc_center_chk #(
  .S3_W(S3_W), .S2_W(S2_W), .SETTLE(SETTLE)
) u_chk (
  .clk(clk), .rst(rst), .s3_tap(s3_tap), .s2_tap(s2_tap),
  .lim_lo(lim_lo), .lim_hi(lim_hi), .busy(busy), .done(done),
  .err(err), .relevel_req(relevel_req)
);

// File: tb/tb_wsc_center_seq.sv
module tb_wsc_center_seq;
  localparam int S3_W = 6;
  localparam int S2_W = 6;
  localparam int QTR  = 8;
  localparam int SETTLE = 16;
  localparam int S2_MAX = (1 << S2_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [3:0] edge_found = '0;
  logic [S3_W-1:0] pos_f2z = '0, pos_z2f = '0, pos_f2o = '0, pos_o2f = '0;
  logic [S3_W-1:0] lim_lo = '0, lim_hi = '0, init_s3 = '0;
  logic [S2_W-1:0] init_s2 = '0;
  logic [S3_W-1:0] s3_tap;
  logic [S2_W-1:0] s2_tap;
  logic busy, done, err, relevel_req;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  int    exp_s3_q[$];
  int    exp_s2_q[$];
  bit    exp_err_q[$];
  string tag_q[$];

  wsc_center_seq #(.S3_W(S3_W), .S2_W(S2_W), .QTR(QTR), .SETTLE(SETTLE)) dut (
    .clk(clk), .rst(rst), .start(start), .edge_found(edge_found),
    .pos_f2z(pos_f2z), .pos_z2f(pos_z2f), .pos_f2o(pos_f2o), .pos_o2f(pos_o2f),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .init_s3(init_s3), .init_s2(init_s2),
    .s3_tap(s3_tap), .s2_tap(s2_tap), .busy(busy), .done(done), .err(err),
    .relevel_req(relevel_req)
  );

  always #5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Target per R4..R7; returns -1 if no rule matches (R9).
  function automatic int model_tgt(bit [3:0] f, int a, int b, int c, int d, int lo, int hi);
    int m;
    if (f[0] && f[1])      m = (a + b) / 2;
    else if (f[1] && f[2]) m = (b + c) / 2 - QTR;
    else if (f[2] && f[3]) m = (c + d) / 2 - 2 * QTR;
    else if (f[1])         m = (lo + b) / 2;
    else if (f[0])         m = (a + hi) / 2;
    else if (f[2])         m = (c + hi) / 2 - 2 * QTR;
    else return -1;
    if (m < lo) m = lo;
    if (m > hi) m = hi;
    return m;
  endfunction

  // Final compensating tap per R1..R3.
  function automatic int model_s2(int s3, int s2, int t);
    while (s3 != t) begin
      if (s3 < t) begin s3++; s2 = (s2 < 2) ? 0 : s2 - 2; end
      else begin s3--; s2 = (s2 > S2_MAX - 2) ? S2_MAX : s2 + 2; end
    end
    return s2;
  endfunction

  task automatic run_case(string tag, bit [3:0] f, int a, int b, int c, int d,
                          int lo, int hi, int i3, int i2, bit poke);
    int t;
    t = model_tgt(f, a, b, c, d, lo, hi);
    if (t < 0) begin
      exp_s3_q.push_back(i3); exp_s2_q.push_back(i2); exp_err_q.push_back(1'b1);
    end else begin
      exp_s3_q.push_back(t); exp_s2_q.push_back(model_s2(i3, i2, t)); exp_err_q.push_back(1'b0);
    end
    tag_q.push_back(tag);
    @(negedge clk);
    edge_found = f;
    pos_f2z = S3_W'(a); pos_z2f = S3_W'(b); pos_f2o = S3_W'(c); pos_o2f = S3_W'(d);
    lim_lo = S3_W'(lo); lim_hi = S3_W'(hi);
    init_s3 = S3_W'(i3); init_s2 = S2_W'(i2);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R8 relevel cleared by start"}, int'(relevel_req), 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      init_s3 = S3_W'(hi); init_s2 = '0; edge_found = 4'b0011;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!(done || err)) @(negedge clk);
    @(negedge clk);
    chk({tag, " R8 done one cycle"}, int'(done), 0);
    chk({tag, " R8 relevel level"}, int'(relevel_req), (t < 0) ? 0 : 1);
    repeat (2) @(negedge clk);
  endtask

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (!rst && (done || err)) begin
      if (tag_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8: unexpected result pulse, actual 1 expected 0");
      end else begin
        int es3, es2; bit ee; string tg;
        es3 = exp_s3_q.pop_front(); es2 = exp_s2_q.pop_front();
        ee = exp_err_q.pop_front(); tg = tag_q.pop_front();
        chk({tg, " fine tap"}, int'(s3_tap), es3);
        chk({tg, " comp tap"}, int'(s2_tap), es2);
        chk({tg, " R9 err kind"}, int'(err), int'(ee));
        chk({tg, " R8 relevel at pulse"}, int'(relevel_req), int'(!ee));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 fine tap", int'(s3_tap), 0);
    chk("R11 comp tap", int'(s2_tap), 0);
    chk("R11 busy", int'(busy), 0);
    chk("R11 pulses", int'(done) + int'(err), 0);
    chk("R11 relevel", int'(relevel_req), 0);
    // R1 R4: pair {f2z,z2f}, downward steps
    run_case("R1 R4 pair01", 4'b0011, 10, 30, 0, 0, 4, 60, 30, 20, 0);
    // R2 R5: pair {z2f,f2o} minus 90, upward steps
    run_case("R2 R5 pair12", 4'b0110, 0, 20, 50, 0, 4, 60, 10, 50, 0);
    // R5 R8: pair {f2o,o2f} minus 180, already on target
    run_case("R5 R8 pair23", 4'b1100, 0, 0, 40, 60, 4, 60, 34, 7, 0);
    // R3 R6: z2f alone with lim_lo, comp tap saturates high
    run_case("R3 R6 z2f only", 4'b0010, 0, 40, 0, 0, 4, 60, 50, 55, 0);
    // R3 R6: f2z alone with lim_hi, comp tap saturates at zero
    run_case("R3 R6 f2z only", 4'b0001, 30, 0, 0, 0, 4, 60, 20, 5, 0);
    // R7: f2o alone minus 180 falls below zero, clamps to lim_lo
    run_case("R7 clamp lo", 4'b0100, 0, 0, 10, 0, 4, 20, 8, 30, 0);
    // R9: no rule matches
    run_case("R9 none", 4'b1000, 0, 0, 0, 0, 4, 60, 17, 9, 0);
    run_case("R9 empty", 4'b0000, 0, 0, 0, 0, 4, 60, 41, 2, 0);
    // R10: second start during run ignored
    run_case("R10 ignored start", 4'b0011, 10, 30, 0, 0, 4, 60, 30, 20, 1);
    // R12 spacing checked by assertion over all runs above
    chk("R8 scoreboard drained", tag_q.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule